// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block produces the timing enables for a UART's serial transmitter and receiver. It takes one of two source clocks: the block's own clock or an external serial clock. The external clock is resynchronized and used one event per rising edge. The source is either passed straight through as the oversample enable, or divided first. Division is a fixed halving, then a prescaler of 1, 4, 16 or 64, then an 8-bit divisor.

Two enables come out, each one clock cycle wide. The oversample enable runs at sixteen times the bit rate. The bit enable fires on every sixteenth oversample enable, in the same cycle. Configuration arrives as a single register write: a 12-bit word captured on a write strobe. A write restarts every counter, so the first enable after it falls exactly one full period later.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted, and in the cycles after reset is released, `os_tick_o` and `bit_tick_o` are low. After reset the configuration is: internal source through the divider, prescaler code 0, divisor 255.
- R2: The source-select field is `cfg_data_i[11:10]`. With code 00 (internal clock direct), `os_tick_o` is high in every cycle from the second cycle after the write on. With code 10 (external clock direct), `os_tick_o` pulses once for each rising edge of `ext_clk_i`.
- R3: Codes 01 (internal) and 11 (external) route the source through the divider. The oversample period is then 2 x F x D source events, where D is the divisor field `cfg_data_i[7:0]`.
- R4: A divisor field of 0 gives the same period as a divisor field of 1.
- R5: `bit_tick_o` fires on every sixteenth `os_tick_o` pulse, in the same cycle as that pulse. It is never high without `os_tick_o`.
- R6: A write (`cfg_wr_i` high for one cycle) clears all counters. Neither output is high in the cycle after the write. With the internal source through the divider, the first `os_tick_o` comes exactly 2 x F x D cycles after the write edge; in direct mode it comes 1 cycle after.
- R7: With the external source through the divider, the oversample period is the external clock period multiplied by 2 x F x D.
- R8: The prescaler code is `cfg_data_i[9:8]`. Codes 0, 1, 2 and 3 give F = 1, 4, 16 and 64.
- R9: Whenever the period is more than one cycle, each `os_tick_o` pulse is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the internal source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External serial clock, asynchronous to clk_i |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 12 | [11:10] source select, [9:8] prescaler code, [7:0] divisor |
| os_tick_o | output | 1 | Oversample enable (16x bit rate), one cycle wide |
| bit_tick_o | output | 1 | Bit-rate enable, every sixteenth oversample enable |

## Verification
The assertions check, on every cycle:
- outputs are quiet right after a write;
- the bit enable always coincides with an oversample enable;
- direct internal mode fires in every cycle;
- the halving stage never fires twice in a row;
- the prescale and divisor counters stay below their terminal counts;
- a zero divisor makes every prescaled event a tick;
- a resynchronized external edge is a single-cycle event.

The exact periods for each prescaler code and divisor, the latency from a write to the first tick, and the sixteen-to-one bit ratio are arithmetic properties over long windows, so only the bench's sweeps can show them. The same holds for multiplication of the external clock period and for a rewrite abandoning a long period partway through.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  // Configuration field widths (divisor, prescaler code, source select)
  parameter int unsigned DIV_W = 8;
  parameter int unsigned PRE_W = 2;
  parameter int unsigned SRC_W = 2;
  parameter int unsigned CFG_W = SRC_W + PRE_W + DIV_W;

  // Source selection: bit 1 picks external, bit 0 routes through the divider
  typedef enum logic [SRC_W-1:0] {
    SRC_INT_DIRECT = 2'b00,
    SRC_INT_DIV    = 2'b01,
    SRC_EXT_DIRECT = 2'b10,
    SRC_EXT_DIV    = 2'b11
  } src_mode_e;

  typedef struct packed {
    src_mode_e          src;
    logic [PRE_W-1:0]   pre;
    logic [DIV_W-1:0]   div;
  } cfg_t;

  parameter cfg_t CFG_RESET = '{src: SRC_INT_DIV, pre: '0, div: '1};

endpackage

// File: rtl/ubg_src_sel.sv
module ubg_src_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic use_ext_i,
  output logic src_en_o
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q, sync_d;
  logic         prev_q, prev_d;
  logic         ext_rise;

  always_comb begin
    sync_d = {sync_q[MSB-1:0], ext_clk_i};
    prev_d = sync_q[MSB];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign ext_rise = sync_q[MSB] & ~prev_q;
  assign src_en_o = use_ext_i ? ext_rise : 1'b1;

  // A resynchronized external edge is a single-cycle event
  AST_EXT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise); // R2

endmodule

// File: rtl/ubg_prescaler.sv
module ubg_prescaler #(
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned PRE_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int unsigned NSEL  = 1 << PRE_W;
  localparam int unsigned CNT_W = PRE_SHIFT * (NSEL - 1);

  logic             half_q, half_d;
  logic             half_tick;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_tbl [NSEL];
  logic [CNT_W-1:0] term;
  logic             at_term;

  // Terminal count per code: 4^code - 1 for a shift of two
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term_tbl[g] = CNT_W'((64'd1 << (g * PRE_SHIFT)) - 64'd1);
  end

  assign term      = term_tbl[sel_i];
  assign half_tick = en_i & half_q;
  assign at_term   = (cnt_q == term);
  assign tick_o    = half_tick & at_term;

  always_comb begin
    half_d = half_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      half_d = 1'b0;
      cnt_d  = '0;
    end else begin
      if (en_i) begin
        half_d = ~half_q;
      end
      if (half_tick) begin
        cnt_d = at_term ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_HALF_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick |=> !half_tick); // R3

  AST_PRE_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $past(!clr_i)) |-> (cnt_q <= term)); // R8

endmodule

// File: rtl/ubg_divisor.sv
module ubg_divisor #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last;
  logic             at_last;

  // A zero divisor counts as one: last index is zero either way
  assign last    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign at_last = (cnt_q == last);
  assign tick_o  = en_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_DIV_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $past(!clr_i)) |-> (cnt_q <= last)); // R3

  AST_DIV_ZERO_AS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && $past(!clr_i) && div_i == '0) |-> tick_o); // R4

endmodule

// File: rtl/ubg_ovs_div.sv
module ubg_ovs_div #(
  parameter int unsigned OVS_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);

  logic [OVS_LOG2-1:0] cnt_q, cnt_d;

  assign tick_o = en_i & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_BIT_ON_OS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> en_i); // R5

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import ubg_pkg::*;
#(
  parameter int unsigned PRE_SHIFT   = 2,
  parameter int unsigned OVS_LOG2    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             os_tick_o,
  output logic             bit_tick_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[RST_STAGES-1];

  // Configuration register
  cfg_t cfg_q, cfg_d;
  logic use_ext;
  logic bypass;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_i) begin
      cfg_d = cfg_t'(cfg_data_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign use_ext = cfg_q.src[1];
  assign bypass  = ~cfg_q.src[0];

  // Datapath
  logic src_en;
  logic pre_tick;
  logic div_tick;
  logic os_fire;
  logic bit_fire;
  logic os_q, os_d;
  logic bit_q, bit_d;

  ubg_src_sel #(
    .SYNC_STAGES (SYNC_STAGES)
  ) i_src_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ext_clk_i (ext_clk_i),
    .use_ext_i (use_ext),
    .src_en_o  (src_en)
  );

  ubg_prescaler #(
    .PRE_W     (PRE_W),
    .PRE_SHIFT (PRE_SHIFT)
  ) i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cfg_wr_i),
    .en_i   (src_en & ~bypass),
    .sel_i  (cfg_q.pre),
    .tick_o (pre_tick)
  );

  ubg_divisor #(
    .DIV_W (DIV_W)
  ) i_divisor (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cfg_wr_i),
    .en_i   (pre_tick),
    .div_i  (cfg_q.div),
    .tick_o (div_tick)
  );

  // A write cycle never produces a tick: counters restart behind it
  assign os_fire = ~cfg_wr_i & (bypass ? src_en : div_tick);

  ubg_ovs_div #(
    .OVS_LOG2 (OVS_LOG2)
  ) i_ovs_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cfg_wr_i),
    .en_i   (os_fire),
    .tick_o (bit_fire)
  );

  always_comb begin
    os_d  = os_fire;
    bit_d = bit_fire;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      os_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      os_q  <= os_d;
      bit_q <= bit_d;
    end
  end

  assign os_tick_o  = os_q;
  assign bit_tick_o = bit_q;

  AST_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_wr_i |=> (!os_tick_o && !bit_tick_o)); // R6

  AST_BIT_WITH_OS: assert property (@(posedge clk_i) disable iff (!rst_n)
    bit_tick_o |-> os_tick_o); // R5

  AST_INT_DIRECT_EVERY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_q.src == SRC_INT_DIRECT && !cfg_wr_i) |=> os_tick_o); // R2

endmodule

// File: tb/test_uart_baud_gen.sv
`timescale 1ns/1ps
module test_uart_baud_gen;

  localparam int WD_LIMIT = 190000;
  localparam int EXT_PER  = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [11:0] cfg_data_i = '0;
  logic        os_tick_o;
  logic        bit_tick_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  uart_baud_gen i_uart_baud_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ext_clk_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_data_i (cfg_data_i),
    .os_tick_o  (os_tick_o),
    .bit_tick_o (bit_tick_o)
  );

  always #2 clk_i = ~clk_i;            // 250 MHz
  always #12 ext_clk_i = ~ext_clk_i;   // six clock cycles per period

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int period_of(input int p, input int d);
    int de;
    de = (d == 0) ? 1 : d;
    return 2 * (1 << (2 * p)) * de;
  endfunction

  // Apply a write; returns at the first falling edge after the write edge
  task automatic cfg_write(input logic [1:0] s, input logic [1:0] p, input logic [7:0] d);
    @(negedge clk_i);
    cfg_wr_i   = 1'b1;
    cfg_data_i = {s, p, d};
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    check("R6 quiet after write", int'(os_tick_o) + int'(bit_tick_o), 0);
  endtask

  // Count falling edges until the chosen output is seen high (-1 on timeout)
  task automatic wait_hi(input bit use_bit, input int limit, output int n);
    logic v;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      v = use_bit ? bit_tick_o : os_tick_o;
    end while (!v && n < limit);
    if (!v) n = -1;
  endtask

  initial begin
    int n;
    int per;
    int dlist [6] = '{0, 1, 2, 3, 17, 255};

    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1 reset os", int'(os_tick_o), 0);
    check("R1 reset bit", int'(bit_tick_o), 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      check("R1 after release", int'(os_tick_o) + int'(bit_tick_o), 0);
    end

    // R3 R4 R6 R8: internal source through divider, every prescaler code
    for (int p = 0; p < 4; p++) begin
      foreach (dlist[i]) begin
        per = period_of(p, dlist[i]);
        cfg_write(2'b01, 2'(p), 8'(dlist[i]));
        wait_hi(1'b0, per + 8, n);
        check($sformatf("R6 R8 first tick p=%0d d=%0d", p, dlist[i]), n, per);
        if (per <= 10000) begin
          @(negedge clk_i);
          check("R9 tick width", int'(os_tick_o), 0);
          wait_hi(1'b0, per + 8, n);
          check($sformatf("R3 R4 period p=%0d d=%0d", p, dlist[i]), n + 1, per);
        end
      end
    end

    // R2: internal direct
    cfg_write(2'b00, 2'd3, 8'd200);
    wait_hi(1'b0, 8, n);
    check("R2 direct first", n, 1);
    wait_hi(1'b0, 8, n);
    check("R2 direct period", n, 1);
    wait_hi(1'b1, 40, n);
    check("R5 direct bit first", n, 14);

    // R5: bit tick in divider mode
    cfg_write(2'b01, 2'd0, 8'd3);
    wait_hi(1'b1, 200, n);
    check("R5 bit first", n, 16 * period_of(0, 3));
    check("R5 bit with os", int'(os_tick_o), 1);
    wait_hi(1'b1, 200, n);
    check("R5 bit period", n, 16 * period_of(0, 3));
    cfg_write(2'b00, 2'd0, 8'd0);
    wait_hi(1'b1, 40, n);
    check("R5 direct bit after write", n, 16);

    // R2: external direct
    cfg_write(2'b10, 2'd0, 8'd1);
    wait_hi(1'b0, 40, n);
    wait_hi(1'b0, 40, n);
    check("R2 ext direct period", n, EXT_PER);

    // R7: external through divider
    cfg_write(2'b11, 2'd0, 8'd2);
    wait_hi(1'b0, 200, n);
    wait_hi(1'b0, 200, n);
    check("R7 ext p0 d2", n, EXT_PER * period_of(0, 2));
    cfg_write(2'b11, 2'd1, 8'd1);
    wait_hi(1'b0, 200, n);
    wait_hi(1'b0, 200, n);
    check("R7 ext p1 d1", n, EXT_PER * period_of(1, 1));
    cfg_write(2'b11, 2'd0, 8'd0);
    wait_hi(1'b0, 200, n);
    wait_hi(1'b0, 200, n);
    check("R7 R4 ext d0", n, EXT_PER * period_of(0, 1));

    // R6: rewrite partway through a long period
    cfg_write(2'b01, 2'd2, 8'd50);
    wait_hi(1'b0, 1000, n);
    check("R6 no early tick", n, -1);
    cfg_write(2'b01, 2'd0, 8'd1);
    wait_hi(1'b0, 20, n);
    check("R6 restart", n, period_of(0, 1));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule